// File: doc/BRIEF.md
# Prioritized Interrupt Exception Entry Unit

This block sits beside a processor's exception sequencer and decides, on a one-cycle evaluate strobe, whether the currently pending interrupt level may be entered. It compares the pending level against the running interrupt level and the number of configured levels. It also checks that at least one interrupt belonging to that level is both raised and enabled. When the interrupt is accepted, the block commits every architectural side effect of entry on a single clock edge: the saved program counter and status copies, the exception cause, the new status word and the address to fetch from next.

Levels above one are vectored directly. Each has its own saved-PC and saved-status slot and its own vector. A level-one interrupt is never vectored by itself. It is folded into the general exception path, and the exception-mode and user-mode bits of the status word select a kernel, user or double exception. Every vector can optionally be relocated against a run-time vector-base value. Fetching from the vector and the return path are left to the surrounding pipeline.

Top module: `irq_entry_unit`

## Requirements
- R1: An evaluation is accepted only if the pending level is strictly above the current level and no larger than NLEVEL (default 6); level 0 is never accepted.
- R2: An evaluation is accepted only if the mask word of the pending level (bits [(L-1)*NINT +: NINT] of the mask table) ANDed with the raised and the enabled interrupt words is nonzero.
- R3: On an accepted level L above 1, the PC is written into saved-PC slot L (epc_o bits [(L-1)*XLEN +: XLEN]) and the incoming status word into saved-status slot L (eps_o, same slicing); no other slot changes.
- R4: On an accepted level L above 1, status_o equals the incoming status with bits [3:0] replaced by L and bit 4 (exception mode) set; kind_o is 1 and next_pc_o is the vector of level L (default offset 0x180 + (L-2)*0x40).
- R5: On an accepted level 1, cause_o becomes 4, status_o equals the incoming status with bit 4 set and all other bits kept, and no saved-status slot changes.
- R6: On an accepted level 1 with status bit 4 already set, kind_o is 4 (double) and next_pc_o is the double vector (offset 0x3C0); the PC goes to depc_o when HAS_DEPC is 1, else to saved-PC slot 1.
- R7: On an accepted level 1 with status bit 4 clear, the PC goes to saved-PC slot 1; status bit 5 (user mode) set gives kind_o 3 with the user vector (offset 0x340), clear gives kind_o 2 with the kernel vector (offset 0x300).
- R8: With RELOC set, every vector equals its default address minus DEF_VECBASE plus vecbase_i; with RELOC clear the default address is used.
- R9: taken_o is high for exactly the one cycle after each accepted evaluation, and all outputs take their new values on that same edge.
- R10: A rejected evaluation, or a cycle without eval_i, changes no output and leaves taken_o low with kind_o 0.
- R11: After synchronous reset every output is zero and kind_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eval_i | input | 1 | Evaluate the pending level this cycle |
| pend_level_i | input | LVL_W | Pending interrupt level |
| cur_level_i | input | LVL_W | Current interrupt level of the core |
| level_mask_i | input | NLEVEL*NINT | Interrupt membership mask per level, level 1 in the low word |
| int_set_i | input | NINT | Raised interrupt lines |
| int_enable_i | input | NINT | Enabled interrupt lines |
| status_i | input | XLEN | Current status word |
| pc_i | input | XLEN | PC of the interrupted instruction |
| vecbase_i | input | XLEN | Run-time vector base |
| taken_o | output | 1 | One-cycle accept pulse |
| kind_o | output | 3 | 0 none, 1 high level, 2 kernel, 3 user, 4 double |
| status_o | output | XLEN | Status word after entry |
| next_pc_o | output | XLEN | Vector to fetch from |
| cause_o | output | CAUSE_W | Exception cause register |
| epc_o | output | NLEVEL*XLEN | Saved-PC slots, level 1 in the low word |
| eps_o | output | NLEVEL*XLEN | Saved-status slots, slot 1 unused (zero) |
| depc_o | output | XLEN | Double-exception saved PC |

## Verification
A wrong accept decision shows in the very next cycle as a taken_o pulse that should not exist or is missing, and the same edge exposes a wrong kind or vector. A write steered to the wrong slot stays hidden until that slot is examined, so the bench compares the whole saved-PC and saved-status bank after every evaluation. A corruption therefore surfaces one cycle after the edge that caused it, even in slots unrelated to the current level. Random levels straddle the current level and the NLEVEL limit, so off-by-one comparisons reach the ports quickly.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  typedef enum logic [2:0] {
    KIND_NONE   = 3'd0,
    KIND_HIGH   = 3'd1,
    KIND_KERNEL = 3'd2,
    KIND_USER   = 3'd3,
    KIND_DOUBLE = 3'd4
  } entry_kind_e;

  // Status word layout
  localparam int PS_LVL_LSB = 0;
  localparam int PS_EXCM    = 4;
  localparam int PS_UM      = 5;

endpackage

// File: rtl/irq_take_check.sv
module irq_take_check #(
  parameter int NLEVEL = 6,
  parameter int NINT   = 32,
  parameter int LVL_W  = 4
) (
  input  logic [LVL_W-1:0]       pend_level_i,
  input  logic [LVL_W-1:0]       cur_level_i,
  input  logic [NLEVEL*NINT-1:0] level_mask_i,
  input  logic [NINT-1:0]        int_set_i,
  input  logic [NINT-1:0]        int_enable_i,
  output logic                   take_o
);

  logic [NINT-1:0]  live;
  logic [NLEVEL:0]  lvl_hit;
  logic             hit_sel;
  logic             lvl_ok;

  assign live       = int_set_i & int_enable_i;
  assign lvl_hit[0] = 1'b0;

  for (genvar g = 1; g <= NLEVEL; g++) begin : g_lvl
    assign lvl_hit[g] = |(level_mask_i[(g-1)*NINT +: NINT] & live);
  end

  always_comb begin
    hit_sel = 1'b0;
    for (int i = 0; i <= NLEVEL; i++) begin
      if (int'(pend_level_i) == i) hit_sel = lvl_hit[i];
    end
  end

  assign lvl_ok = (pend_level_i > cur_level_i) && (int'(pend_level_i) <= NLEVEL);
  assign take_o = lvl_ok && hit_sel;

endmodule

// File: rtl/irq_vector_calc.sv
module irq_vector_calc
  import irq_entry_pkg::*;
#(
  parameter int              XLEN            = 32,
  parameter int              LVL_W           = 4,
  parameter bit              RELOC           = 1'b1,
  parameter logic [XLEN-1:0] DEF_VECBASE     = 32'h4000_0000,
  parameter logic [XLEN-1:0] HIGH_VEC_OFS    = 32'h0000_0180,
  parameter logic [XLEN-1:0] HIGH_VEC_STRIDE = 32'h0000_0040,
  parameter logic [XLEN-1:0] KERNEL_VEC_OFS  = 32'h0000_0300,
  parameter logic [XLEN-1:0] USER_VEC_OFS    = 32'h0000_0340,
  parameter logic [XLEN-1:0] DOUBLE_VEC_OFS  = 32'h0000_03C0
) (
  input  entry_kind_e      kind_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [XLEN-1:0]  vecbase_i,
  output logic [XLEN-1:0]  vector_o
);

  logic [XLEN-1:0] lvl_wide;
  logic [XLEN-1:0] def_vec;

  assign lvl_wide = {{(XLEN-LVL_W){1'b0}}, level_i};

  always_comb begin
    unique case (kind_i)
      KIND_HIGH:   def_vec = DEF_VECBASE + HIGH_VEC_OFS + (lvl_wide - XLEN'(2)) * HIGH_VEC_STRIDE;
      KIND_KERNEL: def_vec = DEF_VECBASE + KERNEL_VEC_OFS;
      KIND_USER:   def_vec = DEF_VECBASE + USER_VEC_OFS;
      KIND_DOUBLE: def_vec = DEF_VECBASE + DOUBLE_VEC_OFS;
      default:     def_vec = DEF_VECBASE;
    endcase
  end

  if (RELOC) begin : g_reloc
    assign vector_o = def_vec - DEF_VECBASE + vecbase_i;
  end else begin : g_fixed
    logic [XLEN-1:0] unused_vb;
    assign unused_vb = vecbase_i;
    assign vector_o  = def_vec;
  end

endmodule

// File: rtl/irq_save_bank.sv
module irq_save_bank
  import irq_entry_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int NLEVEL   = 6,
  parameter int LVL_W    = 4,
  parameter bit HAS_DEPC = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_i,
  input  entry_kind_e            kind_i,
  input  logic [LVL_W-1:0]       level_i,
  input  logic [XLEN-1:0]        pc_i,
  input  logic [XLEN-1:0]        status_i,
  output logic [NLEVEL*XLEN-1:0] epc_o,
  output logic [NLEVEL*XLEN-1:0] eps_o,
  output logic [XLEN-1:0]        depc_o
);

  logic l1_pc_wr;
  logic is_double;

  assign is_double = (kind_i == KIND_DOUBLE);
  assign l1_pc_wr  = wr_i && ((kind_i == KIND_KERNEL) || (kind_i == KIND_USER) ||
                              (is_double && !HAS_DEPC));

  for (genvar g = 1; g <= NLEVEL; g++) begin : g_slot
    logic hi_wr;
    assign hi_wr = wr_i && (kind_i == KIND_HIGH) && (int'(level_i) == g);

    if (g == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst)           epc_o[0 +: XLEN] <= '0;
        else if (l1_pc_wr) epc_o[0 +: XLEN] <= pc_i;
      end
      assign eps_o[0 +: XLEN] = '0;
      logic unused_hi;
      assign unused_hi = hi_wr;
    end else begin : g_high
      always_ff @(posedge clk) begin
        if (rst) begin
          epc_o[(g-1)*XLEN +: XLEN] <= '0;
          eps_o[(g-1)*XLEN +: XLEN] <= '0;
        end else if (hi_wr) begin
          epc_o[(g-1)*XLEN +: XLEN] <= pc_i;
          eps_o[(g-1)*XLEN +: XLEN] <= status_i;
        end
      end
    end
  end

  if (HAS_DEPC) begin : g_depc
    always_ff @(posedge clk) begin
      if (rst)                   depc_o <= '0;
      else if (wr_i && is_double) depc_o <= pc_i;
    end
  end else begin : g_no_depc
    assign depc_o = '0;
  end

endmodule

// File: rtl/irq_entry_unit.sv
module irq_entry_unit
  import irq_entry_pkg::*;
#(
  parameter int              XLEN            = 32,
  parameter int              NLEVEL          = 6,
  parameter int              NINT            = 32,
  parameter int              LVL_W           = 4,
  parameter int              CAUSE_W         = 6,
  parameter logic [CAUSE_W-1:0] CAUSE_L1     = 6'd4,
  parameter bit              HAS_DEPC        = 1'b1,
  parameter bit              RELOC           = 1'b1,
  parameter logic [XLEN-1:0] DEF_VECBASE     = 32'h4000_0000,
  parameter logic [XLEN-1:0] HIGH_VEC_OFS    = 32'h0000_0180,
  parameter logic [XLEN-1:0] HIGH_VEC_STRIDE = 32'h0000_0040,
  parameter logic [XLEN-1:0] KERNEL_VEC_OFS  = 32'h0000_0300,
  parameter logic [XLEN-1:0] USER_VEC_OFS    = 32'h0000_0340,
  parameter logic [XLEN-1:0] DOUBLE_VEC_OFS  = 32'h0000_03C0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   eval_i,
  input  logic [LVL_W-1:0]       pend_level_i,
  input  logic [LVL_W-1:0]       cur_level_i,
  input  logic [NLEVEL*NINT-1:0] level_mask_i,
  input  logic [NINT-1:0]        int_set_i,
  input  logic [NINT-1:0]        int_enable_i,
  input  logic [XLEN-1:0]        status_i,
  input  logic [XLEN-1:0]        pc_i,
  input  logic [XLEN-1:0]        vecbase_i,
  output logic                   taken_o,
  output logic [2:0]             kind_o,
  output logic [XLEN-1:0]        status_o,
  output logic [XLEN-1:0]        next_pc_o,
  output logic [CAUSE_W-1:0]     cause_o,
  output logic [NLEVEL*XLEN-1:0] epc_o,
  output logic [NLEVEL*XLEN-1:0] eps_o,
  output logic [XLEN-1:0]        depc_o
);

  logic            take_ok;
  logic            accept;
  entry_kind_e     kind_d;
  logic [XLEN-1:0] status_d;
  logic [XLEN-1:0] vector_d;

  irq_take_check #(
    .NLEVEL(NLEVEL), .NINT(NINT), .LVL_W(LVL_W)
  ) u_take (
    .pend_level_i (pend_level_i),
    .cur_level_i  (cur_level_i),
    .level_mask_i (level_mask_i),
    .int_set_i    (int_set_i),
    .int_enable_i (int_enable_i),
    .take_o       (take_ok)
  );

  assign accept = eval_i && take_ok;

  // Classify the entry
  always_comb begin
    if (!accept)                     kind_d = KIND_NONE;
    else if (pend_level_i > LVL_W'(1)) kind_d = KIND_HIGH;
    else if (status_i[PS_EXCM])      kind_d = KIND_DOUBLE;
    else if (status_i[PS_UM])        kind_d = KIND_USER;
    else                             kind_d = KIND_KERNEL;
  end

  always_comb begin
    status_d = status_i;
    if (kind_d == KIND_HIGH) status_d[PS_LVL_LSB +: LVL_W] = pend_level_i;
    status_d[PS_EXCM] = 1'b1;
  end

  irq_vector_calc #(
    .XLEN(XLEN), .LVL_W(LVL_W), .RELOC(RELOC), .DEF_VECBASE(DEF_VECBASE),
    .HIGH_VEC_OFS(HIGH_VEC_OFS), .HIGH_VEC_STRIDE(HIGH_VEC_STRIDE),
    .KERNEL_VEC_OFS(KERNEL_VEC_OFS), .USER_VEC_OFS(USER_VEC_OFS),
    .DOUBLE_VEC_OFS(DOUBLE_VEC_OFS)
  ) u_vec (
    .kind_i    (kind_d),
    .level_i   (pend_level_i),
    .vecbase_i (vecbase_i),
    .vector_o  (vector_d)
  );

  irq_save_bank #(
    .XLEN(XLEN), .NLEVEL(NLEVEL), .LVL_W(LVL_W), .HAS_DEPC(HAS_DEPC)
  ) u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_i     (accept),
    .kind_i   (kind_d),
    .level_i  (pend_level_i),
    .pc_i     (pc_i),
    .status_i (status_i),
    .epc_o    (epc_o),
    .eps_o    (eps_o),
    .depc_o   (depc_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      taken_o   <= 1'b0;
      kind_o    <= KIND_NONE;
      status_o  <= '0;
      next_pc_o <= '0;
      cause_o   <= '0;
    end else begin
      taken_o <= accept;
      kind_o  <= kind_d;
      if (accept) begin
        status_o  <= status_d;
        next_pc_o <= vector_d;
        if (kind_d != KIND_HIGH) cause_o <= CAUSE_L1;
      end
    end
  end

endmodule

// File: rtl/irq_entry_unit_chk.sv
module irq_entry_unit_chk #(
  parameter int XLEN    = 32,
  parameter int NLEVEL  = 6,
  parameter int LVL_W   = 4,
  parameter int CAUSE_W = 6,
  parameter logic [CAUSE_W-1:0] CAUSE_L1 = 6'd4
) (
  input logic               clk,
  input logic               rst,
  input logic [LVL_W-1:0]   pend_level_i,
  input logic [LVL_W-1:0]   cur_level_i,
  input logic [XLEN-1:0]    status_i,
  input logic               taken_o,
  input logic [2:0]         kind_o,
  input logic [XLEN-1:0]    status_o,
  input logic [CAUSE_W-1:0] cause_o
);

  // R1: accepted level lies in (current, NLEVEL]
  a_r1_level_window: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> (($past(pend_level_i) > $past(cur_level_i)) &&
                 (int'($past(pend_level_i)) <= NLEVEL)));

  // R4: high level entry sets the level field and exception mode
  a_r4_high_status: assert property (@(posedge clk) disable iff (rst)
    (taken_o && kind_o == 3'd1) |->
      (status_o[3:0] == $past(pend_level_i) && status_o[4]));

  // R5: level-one entry loads the cause code and sets exception mode
  a_r5_l1_cause: assert property (@(posedge clk) disable iff (rst)
    (taken_o && kind_o != 3'd1) |-> (cause_o == CAUSE_L1 && status_o[4]));

  // R6: double exception only from exception mode
  a_r6_double_src: assert property (@(posedge clk) disable iff (rst)
    (kind_o == 3'd4) |-> $past(status_i[4]));

  // R7: user exception only from user mode outside exception mode
  a_r7_user_src: assert property (@(posedge clk) disable iff (rst)
    (kind_o == 3'd3) |-> ($past(status_i[5]) && !$past(status_i[4])));

  // R10: nothing moves without an accept
  a_r10_hold_state: assert property (@(posedge clk) disable iff (rst)
    !taken_o |-> ($stable(status_o) && $stable(cause_o) && kind_o == 3'd0));

endmodule

bind irq_entry_unit irq_entry_unit_chk #(
  .XLEN(XLEN), .NLEVEL(NLEVEL), .LVL_W(LVL_W), .CAUSE_W(CAUSE_W), .CAUSE_L1(CAUSE_L1)
) u_chk (
  .clk(clk), .rst(rst), .pend_level_i(pend_level_i), .cur_level_i(cur_level_i),
  .status_i(status_i), .taken_o(taken_o), .kind_o(kind_o), .status_o(status_o),
  .cause_o(cause_o)
);

// File: tb/irq_entry_unit_tb_top.sv
`timescale 1ns/1ps
module irq_entry_unit_tb_top;

  localparam int XLEN = 32, NLEVEL = 6, NINT = 32, LVL_W = 4, CAUSE_W = 6;
  localparam logic [31:0] DEFVB = 32'h4000_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic eval_i = 1'b0;
  logic [LVL_W-1:0] pend_level_i = '0, cur_level_i = '0;
  logic [NLEVEL*NINT-1:0] level_mask_i = '0;
  logic [NINT-1:0] int_set_i = '0, int_enable_i = '0;
  logic [XLEN-1:0] status_i = '0, pc_i = '0, vecbase_i = '0;
  logic taken_o;
  logic [2:0] kind_o;
  logic [XLEN-1:0] status_o, next_pc_o, depc_o;
  logic [CAUSE_W-1:0] cause_o;
  logic [NLEVEL*XLEN-1:0] epc_o, eps_o;

  always #4 clk = ~clk;

  irq_entry_unit dut_i (.*);

  int n_run = 0, n_fail = 0;
  logic [31:0] e_epc [1:NLEVEL];
  logic [31:0] e_eps [1:NLEVEL];
  logic [31:0] e_depc, e_ps, e_pc;
  logic [5:0]  e_cause;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit model_take(int p, int c);
    logic [NINT-1:0] m;
    if (p <= c || p > NLEVEL || p == 0) return 0;
    m = level_mask_i[(p-1)*NINT +: NINT];
    return |(m & int_set_i & int_enable_i);
  endfunction

  function automatic logic [31:0] reloc(logic [31:0] ofs);
    return (DEFVB + ofs) - DEFVB + vecbase_i;
  endfunction

  task automatic check_bank(input string tag);
    for (int l = 1; l <= NLEVEL; l++) begin
      chk({tag, " R3/R7 epc"}, epc_o[(l-1)*XLEN +: XLEN], e_epc[l]);
      chk({tag, " R3/R5 eps"}, eps_o[(l-1)*XLEN +: XLEN], e_eps[l]);
    end
    chk({tag, " R6 depc"}, depc_o, e_depc);
  endtask

  // One evaluation with current inputs, then compare against the model
  task automatic run_case(input string tag);
    int p, c, k;
    bit t;
    p = int'(pend_level_i);
    c = int'(cur_level_i);
    t = model_take(p, c);
    k = 0;
    if (t) begin
      if (p > 1) begin
        k = 1;
        e_epc[p] = pc_i;
        e_eps[p] = status_i;
        e_ps = {status_i[31:5], 1'b1, 4'(p)};
        e_pc = reloc(32'h180 + 32'(p - 2) * 32'h40);
      end else begin
        e_cause = 6'd4;
        e_ps = status_i | 32'h10;
        if (status_i[4]) begin
          k = 4; e_depc = pc_i; e_pc = reloc(32'h3C0);
        end else begin
          e_epc[1] = pc_i;
          k = status_i[5] ? 3 : 2;
          e_pc = reloc(status_i[5] ? 32'h340 : 32'h300);
        end
      end
    end
    eval_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    eval_i = 1'b0;
    chk({tag, t ? " R9 taken" : " R1/R2/R10 taken"}, 32'(taken_o), 32'(t));
    chk({tag, " R6/R7/R4 kind"}, 32'(kind_o), 32'(k));
    chk({tag, " R4/R5/R10 status"}, status_o, e_ps);
    chk({tag, " R5 cause"}, 32'(cause_o), 32'(e_cause));
    if (t) chk({tag, " R8 next_pc"}, next_pc_o, e_pc);
    check_bank(tag);
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R9 pulse"}, 32'(taken_o), 32'd0);
    chk({tag, " R10 idle kind"}, 32'(kind_o), 32'd0);
  endtask

  task automatic setup(input int p, input int c, input logic [31:0] st, input bit live);
    pend_level_i = LVL_W'(p);
    cur_level_i  = LVL_W'(c);
    status_i     = st;
    pc_i         = $urandom;
    vecbase_i    = $urandom & 32'hFFFF_F000;
    int_set_i    = live ? 32'hFFFF_FFFF : 32'h0;
    int_enable_i = 32'hFFFF_FFFF;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int l = 1; l <= NLEVEL; l++) begin e_epc[l] = '0; e_eps[l] = '0; end
    e_depc = '0; e_ps = '0; e_cause = '0; e_pc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk("R11 taken", 32'(taken_o), 0);
    chk("R11 kind", 32'(kind_o), 0);
    chk("R11 status", status_o, 0);
    chk("R11 next_pc", next_pc_o, 0);
    chk("R11 cause", 32'(cause_o), 0);
    check_bank("R11");

    for (int l = 0; l < NLEVEL; l++) level_mask_i[l*NINT +: NINT] = 32'h1 << (l * 4);

    // R1 boundaries
    setup(3, 3, 32'h0, 1); run_case("R1 equal");
    setup(4, 3, 32'h3, 1); run_case("R1 above");
    setup(NLEVEL, 0, 32'h0, 1); run_case("R1 max");
    setup(NLEVEL + 1, 0, 32'h0, 1); run_case("R1 over");
    setup(0, 0, 32'h0, 1); run_case("R1 zero");
    // R2 masking: lines raised but not in this level, then disabled
    setup(2, 0, 32'h0, 0); int_set_i = 32'h1; run_case("R2 foreign");
    setup(2, 0, 32'h0, 1); int_enable_i = 32'h0; run_case("R2 disabled");
    // R3/R4 high level
    setup(5, 1, 32'h0000_0021, 1); run_case("R3 high5");
    // R7 kernel and user, R6 double
    setup(1, 0, 32'h0, 1); run_case("R7 kernel");
    setup(1, 0, 32'h20, 1); run_case("R7 user");
    setup(1, 0, 32'h30, 1); run_case("R6 double");

    // Random mix, R8 covered by random vector bases
    for (int i = 0; i < 400; i++) begin
      for (int l = 0; l < NLEVEL; l++) level_mask_i[l*NINT +: NINT] = $urandom & $urandom;
      pend_level_i = LVL_W'($urandom_range(0, NLEVEL + 1));
      cur_level_i  = LVL_W'($urandom_range(0, NLEVEL));
      int_set_i    = $urandom;
      int_enable_i = $urandom;
      status_i     = $urandom & 32'h0000_00FF;
      pc_i         = $urandom;
      vecbase_i    = $urandom & 32'hFFFF_F000;
      run_case("rand");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule